// File: doc/BRIEF.md
# Two-Wire Bus Line Conditioner and Event Detector

This block sits between the raw clock and data pins of a two-wire serial bus and a protocol engine that runs on a much faster system clock. It brings each line into the system clock domain through a short synchroniser chain. It then removes any pulse narrower than a minimum width, set in nanoseconds by a parameter. From the cleaned levels it derives one-cycle strobes that tell the protocol engine what happened on the bus.

The strobes cover four bus events and one fault:
- a start condition (data falls while the clock line stays high);
- a stop condition (data rises while the clock line stays high);
- clock rising and clock falling edges;
- an illegal data change, where both cleaned lines change in the same system cycle and the order of the two changes cannot be known.

The cleaned line levels are also output, aligned with the strobes. The protocol engine samples incoming bits on the clock rising strobe and changes outgoing bits after the clock falling strobe.

Top module: `twb_cond_detect`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both cleaned levels read 1 (idle bus) and every strobe is 0.
- R2: A data line fall accepted by the filter while the cleaned clock level is and stays 1 raises `start_stb` for exactly one cycle.
- R3: A data line rise accepted by the filter while the cleaned clock level is and stays 1 raises `stop_stb` for exactly one cycle.
- R4: Each accepted clock line transition raises `scl_rise_stb` (level 0 to 1) or `scl_fall_stb` (level 1 to 0) for exactly one cycle.
- R5: Data line changes while the cleaned clock level is 0 update `sda_lvl` and raise no start, stop or illegal strobe.
- R6: A raw pulse shorter than FILT_LEN system cycles leaves the cleaned level unchanged and produces no strobe. FILT_LEN is ceil(MIN_PULSE_NS / CLK_PERIOD_NS), which is 3 at the default values.
- R7: A raw level held for exactly FILT_LEN system cycles is accepted.
- R8: A raw change reaches the strobe and level outputs SYNC_STAGES + FILT_LEN + 1 system cycles after the first clock edge that samples it. This is 6 cycles at the default values.
- R9: If both cleaned levels change in the same cycle, `sda_illegal_stb` pulses for one cycle, no start or stop strobe is produced, and the matching clock edge strobe is still produced.
- R10: `start_stb`, `stop_stb` and `sda_illegal_stb` are never high together, and no strobe stays high for two consecutive cycles after one transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_raw | input | 1 | Raw bus clock line |
| sda_raw | input | 1 | Raw bus data line |
| scl_lvl | output | 1 | Filtered clock line level |
| sda_lvl | output | 1 | Filtered data line level |
| start_stb | output | 1 | One-cycle start condition strobe |
| stop_stb | output | 1 | One-cycle stop condition strobe |
| scl_rise_stb | output | 1 | One-cycle clock rising edge strobe |
| scl_fall_stb | output | 1 | One-cycle clock falling edge strobe |
| sda_illegal_stb | output | 1 | One-cycle strobe for data and clock changing in the same cycle |

## Verification
Two functions can fall in the same cycle: clock edge detection and the start/stop classification of a data change.

The bench provokes this by changing both raw lines on the same system clock edge. Both changes then travel through identical synchroniser and filter paths and arrive at the classifier together.

The result is judged by three outcomes:
- exactly one illegal-change strobe;
- exactly one clock falling strobe;
- no start strobe, even though the data line fell while the clock was last seen high.

// File: rtl/twb_pkg.sv
package twb_pkg;

  // Number of system cycles needed to span at least min_ns.
  function automatic int filt_cycles(input int period_ns, input int min_ns);
    int n;
    n = (min_ns + period_ns - 1) / period_ns;
    if (n < 1) n = 1;
    return n;
  endfunction

  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
  localparam int NUM_LINES = 2;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic illegal;
  } twb_evt_t;

endpackage

// File: rtl/twb_sync.sv
module twb_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/twb_glitch_filter.sv
module twb_glitch_filter #(
  parameter int   FILT_LEN = 3,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic lvl
);
  localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [CW-1:0] run;

  // A new value must disagree with the held level for FILT_LEN
  // consecutive samples before it replaces it.
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= RST_VAL;
      run <= '0;
    end else if (d == lvl) begin
      run <= '0;
    end else if (run == LAST) begin
      lvl <= d;
      run <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/twb_event_classify.sv
module twb_event_classify
  import twb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_f,
  input  logic     sda_f,
  output logic     scl_q,
  output logic     sda_q,
  output twb_evt_t evt_q
);
  logic     scl_chg, sda_chg;
  twb_evt_t evt_d;

  assign scl_chg = scl_f ^ scl_q;
  assign sda_chg = sda_f ^ sda_q;

  always_comb begin
    evt_d         = '0;
    evt_d.rise    = scl_chg &  scl_f;
    evt_d.fall    = scl_chg & ~scl_f;
    evt_d.illegal = scl_chg & sda_chg;
    if (sda_chg && !scl_chg && scl_f) begin
      evt_d.start = ~sda_f;
      evt_d.stop  =  sda_f;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      evt_q <= '0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      evt_q <= evt_d;
    end
  end
endmodule

// File: rtl/twb_cond_detect.sv
module twb_cond_detect
  import twb_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int MIN_PULSE_NS  = 50,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic start_stb,
  output logic stop_stb,
  output logic scl_rise_stb,
  output logic scl_fall_stb,
  output logic sda_illegal_stb
);
  localparam int FILT_LEN = filt_cycles(CLK_PERIOD_NS, MIN_PULSE_NS);

  logic [NUM_LINES-1:0] raw, synced, filt;
  twb_evt_t             evt;

  assign raw[LINE_SCL] = scl_raw;
  assign raw[LINE_SDA] = sda_raw;

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      twb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(raw[i]), .q(synced[i])
      );
      twb_glitch_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_filt (
        .clk(clk), .rst(rst), .d(synced[i]), .lvl(filt[i])
      );
    end
  endgenerate

  twb_event_classify u_cls (
    .clk(clk), .rst(rst),
    .scl_f(filt[LINE_SCL]), .sda_f(filt[LINE_SDA]),
    .scl_q(scl_lvl), .sda_q(sda_lvl), .evt_q(evt)
  );

  assign start_stb       = evt.start;
  assign stop_stb        = evt.stop;
  assign scl_rise_stb    = evt.rise;
  assign scl_fall_stb    = evt.fall;
  assign sda_illegal_stb = evt.illegal;
endmodule

// File: rtl/twb_cond_checker.sv
module twb_cond_checker (
  input logic clk,
  input logic rst,
  input logic scl_lvl,
  input logic sda_lvl,
  input logic start_stb,
  input logic stop_stb,
  input logic scl_rise_stb,
  input logic scl_fall_stb,
  input logic sda_illegal_stb
);
  p_start_cond_r2: assert property (@(posedge clk) disable iff (rst)
    start_stb |-> (scl_lvl && $past(scl_lvl) && !sda_lvl && $past(sda_lvl)));

  p_stop_cond_r3: assert property (@(posedge clk) disable iff (rst)
    stop_stb |-> (scl_lvl && $past(scl_lvl) && sda_lvl && !$past(sda_lvl)));

  p_rise_edge_r4: assert property (@(posedge clk) disable iff (rst)
    scl_rise_stb |-> (scl_lvl && !$past(scl_lvl)));

  p_fall_edge_r4: assert property (@(posedge clk) disable iff (rst)
    scl_fall_stb |-> (!scl_lvl && $past(scl_lvl)));

  p_scl_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(scl_rise_stb || scl_fall_stb) |-> $stable(scl_lvl));

  p_illegal_both_r9: assert property (@(posedge clk) disable iff (rst)
    sda_illegal_stb |-> (scl_rise_stb || scl_fall_stb) && !$stable(sda_lvl));

  p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_stb, stop_stb, sda_illegal_stb}));

  p_start_once_r10: assert property (@(posedge clk) disable iff (rst)
    start_stb |=> !start_stb);

  p_stop_once_r10: assert property (@(posedge clk) disable iff (rst)
    stop_stb |=> !stop_stb);
endmodule

bind twb_cond_detect twb_cond_checker u_chk (
  .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
  .start_stb(start_stb), .stop_stb(stop_stb),
  .scl_rise_stb(scl_rise_stb), .scl_fall_stb(scl_fall_stb),
  .sda_illegal_stb(sda_illegal_stb)
);

// File: tb/sim_twb_cond_detect.sv
`timescale 1ns/1ps
module sim_twb_cond_detect;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_raw = 1'b1;
  logic sda_raw = 1'b1;
  logic scl_lvl, sda_lvl, start_stb, stop_stb, scl_rise_stb, scl_fall_stb, sda_illegal_stb;

  int n_cmp = 0;
  int n_bad = 0;
  int c_start = 0, c_stop = 0, c_rise = 0, c_fall = 0, c_ill = 0, c_long = 0;
  logic p_start = 0, p_stop = 0, p_rise = 0, p_fall = 0, p_ill = 0;
  bit done = 0;

  always #10 clk = ~clk;

  twb_cond_detect u0 (
    .clk(clk), .rst(rst), .scl_raw(scl_raw), .sda_raw(sda_raw),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .start_stb(start_stb),
    .stop_stb(stop_stb), .scl_rise_stb(scl_rise_stb),
    .scl_fall_stb(scl_fall_stb), .sda_illegal_stb(sda_illegal_stb)
  );

  // Strobe monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      c_start += int'(start_stb);
      c_stop  += int'(stop_stb);
      c_rise  += int'(scl_rise_stb);
      c_fall  += int'(scl_fall_stb);
      c_ill   += int'(sda_illegal_stb);
      if ((start_stb && p_start) || (stop_stb && p_stop) || (scl_rise_stb && p_rise) ||
          (scl_fall_stb && p_fall) || (sda_illegal_stb && p_ill))
        c_long += 1;
      if ((int'(start_stb) + int'(stop_stb) + int'(sda_illegal_stb)) > 1)
        c_long += 1;
    end
    p_start = start_stb;
    p_stop  = stop_stb;
    p_rise  = scl_rise_stb;
    p_fall  = scl_fall_stb;
    p_ill   = sda_illegal_stb;
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic drive(input logic s, input logic d);
    @(negedge clk);
    scl_raw = s;
    sda_raw = d;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 scl_lvl in reset", int'(scl_lvl), 1);
    check("R1 sda_lvl in reset", int'(sda_lvl), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 levels after reset", int'({scl_lvl, sda_lvl}), 3);
    check("R1 strobes after reset",
          int'({start_stb, stop_stb, scl_rise_stb, scl_fall_stb, sda_illegal_stb}), 0);
    settle();
  endtask

  // Start condition; also measures the latency.
  task automatic t_start_latency();
    int s0;
    int hit;
    s0 = c_start;
    hit = 0;
    @(negedge clk);
    sda_raw = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (start_stb) hit = hit * 10 + k;
    end
    check("R8 start strobe cycle", hit, 6);
    settle();
    check("R2 one start", c_start - s0, 1);
    check("R2 sda_lvl low", int'(sda_lvl), 0);
  endtask

  task automatic t_stop();
    int s0 = c_stop;
    drive(1'b1, 1'b1);
    settle();
    check("R3 one stop", c_stop - s0, 1);
    check("R3 sda_lvl high", int'(sda_lvl), 1);
  endtask

  task automatic t_edges();
    int r0 = c_rise;
    int f0 = c_fall;
    drive(1'b0, 1'b1);
    settle();
    check("R4 fall strobe", c_fall - f0, 1);
    check("R4 scl_lvl low", int'(scl_lvl), 0);
    drive(1'b1, 1'b1);
    settle();
    check("R4 rise strobe", c_rise - r0, 1);
  endtask

  task automatic t_data_low();
    int s0 = c_start;
    int p0 = c_stop;
    int i0 = c_ill;
    drive(1'b0, 1'b1);
    settle();
    drive(1'b0, 1'b0);
    settle();
    check("R5 sda follows while scl low", int'(sda_lvl), 0);
    drive(1'b0, 1'b1);
    settle();
    drive(1'b0, 1'b0);
    settle();
    drive(1'b0, 1'b1);
    settle();
    check("R5 no start/stop/illegal", (c_start - s0) + (c_stop - p0) + (c_ill - i0), 0);
    drive(1'b1, 1'b1);
    settle();
  endtask

  task automatic t_glitch();
    int s0 = c_start;
    int p0 = c_stop;
    int f0 = c_fall;
    drive(1'b1, 1'b0);
    @(negedge clk);
    @(negedge clk);
    sda_raw = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!sda_lvl) s0 -= 100;
    end
    check("R6 sda short pulse ignored", (c_start - s0) + (c_stop - p0), 0);
    drive(1'b0, 1'b1);
    @(negedge clk);
    @(negedge clk);
    scl_raw = 1'b1;
    settle();
    check("R6 scl short pulse ignored", c_fall - f0, 0);
    check("R6 scl_lvl stays high", int'(scl_lvl), 1);
  endtask

  task automatic t_min_width();
    int s0 = c_start;
    int p0 = c_stop;
    drive(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    sda_raw = 1'b1;
    settle();
    check("R7 min pulse start", c_start - s0, 1);
    check("R7 min pulse stop", c_stop - p0, 1);
  endtask

  task automatic t_simultaneous();
    int s0 = c_start;
    int i0 = c_ill;
    int f0 = c_fall;
    drive(1'b0, 1'b0);
    settle();
    check("R9 illegal strobe", c_ill - i0, 1);
    check("R9 no start", c_start - s0, 0);
    check("R9 fall still reported", c_fall - f0, 1);
    drive(1'b1, 1'b0);
    settle();
    drive(1'b1, 1'b1);
    settle();
  endtask

  initial begin
    t_reset();
    t_start_latency();
    t_stop();
    t_edges();
    t_data_low();
    t_glitch();
    t_min_width();
    t_simultaneous();
    check("R10 single-cycle and exclusive strobes", c_long, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule